// File: doc/BRIEF.md
# Receive Ring Buffer Writer

This block stores received Ethernet frames into a circular packet buffer made of 256-byte pages. The ring occupies the pages from a start page up to, but not including, a stop page. For each frame, the block first takes a length descriptor. It then decides whether the frame can be stored. A frame is stored only when the receiver is running and the ring has room for a frame of the largest size. A stored frame is written one byte per clock through a synchronous RAM write port. Four header bytes go at the start of the current page, and the frame body follows them. When the last byte has gone out, the block moves the current page to the page named in the header and raises a receive-done status flag.

The start page, stop page, boundary page, run/stop state and interrupt mask are plain inputs, held by host-side registers outside the block. The current page is held inside the block. The host can load it when the block is idle, and the block reports it on an output.

Frames arrive on two valid/ready streams. On the descriptor stream, `hdr_ready` is high only while the block is idle, and a descriptor moves on a cycle where `hdr_valid` and `hdr_ready` are both high. On the data stream, `dat_ready` is high only while the block is storing frame bytes or discarding the bytes of a dropped frame. A byte moves on a cycle where `dat_valid` and `dat_ready` are both high. The sender may hold `dat_valid` low for any number of cycles. Configuration inputs must not change while `busy` is high.

Top module: `rrb_ring_writer`

## Requirements
- R1: A descriptor is accepted only when `hdr_valid` and `hdr_ready` are both high. `busy` rises in the cycle after acceptance and stays high until the cycle after the current-page update. `mem_we` is high only while `busy` is high.
- R2: A frame is dropped when `cmd_stop` is high at acceptance or when the ring counts as full. A dropped frame causes no RAM write and no change to `cur_pg`. It does not set `rx_flag`. Its `hdr_len` data bytes are still consumed.
- R3: Free bytes are computed from byte addresses, where a byte address is a page number times 256. When current is below boundary, free = boundary − current. Otherwise, free = (stop − start) − (current − boundary). The ring counts as full when free < 1518, or when the stop page is at or below the start page.
- R4: A stored frame gets a 4-byte header at byte address `cur_pg`·256, in this order: status byte 0x01, next-packet page, total length low byte, total length high byte. Total length is the padded frame length plus 4.
- R5: A frame shorter than 60 bytes is padded with zero bytes up to 60 bytes. A frame of length 0 stores 60 zero bytes.
- R6: Frame bytes are written from `cur_pg`·256+4 in increasing order. When the next address would equal stop·256, writing continues at start·256. Every write lands in a page from start to stop−1.
- R7: The next-packet page is `cur_pg` + ceil((total length + 4)/256). When the result is at or above the stop page, (stop − start) is subtracted from it.
- R8: After the last byte of a stored frame, `cur_pg` takes the next-packet page and `rx_flag` is set. `cur_pg` otherwise changes only through a host load.
- R9: `irq` is high exactly when the status byte {7'b0, `rx_flag`}, ANDed with `irq_mask` and with 0x7F, is nonzero.
- R10: `cur_ld` loads `cur_ld_pg` into `cur_pg` when the block is idle. While `busy` is high, `cur_ld` is ignored.
- R11: A frame byte is written only on a data handshake. Gaps in `dat_valid` stall the write without losing or repeating a byte.
- R12: `isr_clr` bit 0 clears `rx_flag`. In a cycle where `rx_flag` is both set and cleared, setting wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_start_pg | input | 8 | First page of the ring |
| cfg_stop_pg | input | 8 | Page just past the ring |
| cfg_bnd_pg | input | 8 | Boundary page (oldest page not yet read by the host) |
| cmd_stop | input | 1 | Receiver stopped; frames are dropped |
| irq_mask | input | 8 | Interrupt mask |
| isr_clr | input | 8 | Write-one-to-clear for status; bit 0 clears `rx_flag` |
| cur_ld | input | 1 | Host load strobe for the current page |
| cur_ld_pg | input | 8 | Value for the host load |
| hdr_valid | input | 1 | Descriptor valid |
| hdr_ready | output | 1 | Descriptor ready (block idle) |
| hdr_len | input | 11 | Frame length in bytes (0 to 1514) |
| dat_valid | input | 1 | Frame byte valid |
| dat_ready | output | 1 | Frame byte ready |
| dat_data | input | 8 | Frame byte |
| mem_we | output | 1 | RAM write enable |
| mem_addr | output | 16 | RAM byte address |
| mem_wdata | output | 8 | RAM write data |
| busy | output | 1 | Frame in progress |
| cur_pg | output | 8 | Current page |
| rx_flag | output | 1 | Receive-done status |
| irq | output | 1 | Interrupt request |

## Verification
The assertions check the following on every cycle:
- writes stay inside the ring pages;
- no write happens outside a busy interval, or without a byte handshake during the data phase;
- a busy interval starts only from an accepted descriptor;
- a stopped receiver issues no write;
- the current page moves only at the end of a frame or on an idle host load;
- `irq` stays low whenever `rx_flag` is clear.

Only the bench scenarios can show the following:
- the free-space rule at its page boundaries;
- the header byte values;
- the zero padding;
- the split of frame data across the wrap point;
- the next-page arithmetic, both with and without wrap.

// File: rtl/rrb_pkg.sv
package rrb_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_HDR  = 3'd1,
    ST_DATA = 3'd2,
    ST_PAD  = 3'd3,
    ST_UPD  = 3'd4,
    ST_DROP = 3'd5
  } wr_state_t;

  localparam logic [7:0] RX_GOOD = 8'h01;
endpackage

// File: rtl/rrb_space.sv
// Full detection: free bytes between current write page and boundary page.
module rrb_space #(
  parameter int PG_W     = 8,
  parameter int OFF_W    = 8,
  parameter int NEED_BYT = 1518
) (
  input  logic [PG_W-1:0] start_pg,
  input  logic [PG_W-1:0] stop_pg,
  input  logic [PG_W-1:0] bnd_pg,
  input  logic [PG_W-1:0] cur_pg,
  output logic            full
);
  localparam int AW = PG_W + OFF_W;

  logic [AW:0] idx_b, bnd_b, ring_b, free_b;

  always_comb begin
    idx_b  = {1'b0, cur_pg, {OFF_W{1'b0}}};
    bnd_b  = {1'b0, bnd_pg, {OFF_W{1'b0}}};
    ring_b = {1'b0, stop_pg - start_pg, {OFF_W{1'b0}}};
    if (idx_b < bnd_b) free_b = bnd_b - idx_b;
    else               free_b = ring_b - (idx_b - bnd_b);
    full = (stop_pg <= start_pg) || (free_b < (AW+1)'(NEED_BYT));
  end
endmodule

// File: rtl/rrb_link.sv
// Next-packet page: whole pages covering header, body and 4 trailing bytes.
module rrb_link #(
  parameter int PG_W  = 8,
  parameter int OFF_W = 8,
  parameter int TOT_W = 12
) (
  input  logic [PG_W-1:0]  start_pg,
  input  logic [PG_W-1:0]  stop_pg,
  input  logic [PG_W-1:0]  cur_pg,
  input  logic [TOT_W-1:0] total,
  output logic [PG_W-1:0]  next_pg
);
  localparam int PG_SZ = 1 << OFF_W;

  logic [TOT_W:0] span;
  logic [PG_W:0]  pages, sum;

  always_comb begin
    span  = {1'b0, total} + (TOT_W+1)'(4 + PG_SZ - 1);
    pages = (PG_W+1)'(span >> OFF_W);
    sum   = {1'b0, cur_pg} + pages;
    if (sum >= {1'b0, stop_pg}) sum = sum - {1'b0, stop_pg - start_pg};
    next_pg = sum[PG_W-1:0];
  end
endmodule

// File: rtl/rrb_addr.sv
// Byte address advance with wrap from the stop page to the start page.
module rrb_addr #(
  parameter int PG_W  = 8,
  parameter int OFF_W = 8
) (
  input  logic [PG_W+OFF_W-1:0] addr,
  input  logic [PG_W-1:0]       start_pg,
  input  logic [PG_W-1:0]       stop_pg,
  output logic [PG_W+OFF_W-1:0] addr_nx
);
  localparam int AW = PG_W + OFF_W;

  logic [AW:0] inc;

  always_comb begin
    inc = {1'b0, addr} + (AW+1)'(1);
    if (inc == {1'b0, stop_pg, {OFF_W{1'b0}}}) addr_nx = {start_pg, {OFF_W{1'b0}}};
    else                                       addr_nx = inc[AW-1:0];
  end
endmodule

// File: rtl/rrb_ring_writer.sv
module rrb_ring_writer
  import rrb_pkg::*;
#(
  parameter int PG_W      = 8,
  parameter int OFF_W     = 8,
  parameter int LEN_W     = 11,
  parameter int MAX_FRAME = 1514,
  parameter int MIN_FRAME = 60,
  parameter int HDR_BYTES = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [PG_W-1:0]       cfg_start_pg,
  input  logic [PG_W-1:0]       cfg_stop_pg,
  input  logic [PG_W-1:0]       cfg_bnd_pg,
  input  logic                  cmd_stop,
  input  logic [7:0]            irq_mask,
  input  logic [7:0]            isr_clr,
  input  logic                  cur_ld,
  input  logic [PG_W-1:0]       cur_ld_pg,
  input  logic                  hdr_valid,
  output logic                  hdr_ready,
  input  logic [LEN_W-1:0]      hdr_len,
  input  logic                  dat_valid,
  output logic                  dat_ready,
  input  logic [7:0]            dat_data,
  output logic                  mem_we,
  output logic [PG_W+OFF_W-1:0] mem_addr,
  output logic [7:0]            mem_wdata,
  output logic                  busy,
  output logic [PG_W-1:0]       cur_pg,
  output logic                  rx_flag,
  output logic                  irq
);
  localparam int AW    = PG_W + OFF_W;
  localparam int TOT_W = LEN_W + 1;
  localparam int HC_W  = $clog2(HDR_BYTES);

  wr_state_t        state;
  logic [HC_W-1:0]  hcnt;
  logic [LEN_W-1:0] rem, pad_rem;
  logic [AW-1:0]    wa, wa_nx;
  logic [PG_W-1:0]  nxt_q, cur_q, nxt_c;
  logic [TOT_W-1:0] tot_q, tot_c;
  logic [LEN_W-1:0] len_pad;
  logic             full_c, acc, flag_q, flag_set;
  logic [7:0]       hdr_byte, status_vec;

  rrb_space #(.PG_W(PG_W), .OFF_W(OFF_W), .NEED_BYT(MAX_FRAME + 4)) u_space (
    .start_pg(cfg_start_pg), .stop_pg(cfg_stop_pg), .bnd_pg(cfg_bnd_pg),
    .cur_pg(cur_q), .full(full_c));

  always_comb begin
    len_pad = (hdr_len < LEN_W'(MIN_FRAME)) ? LEN_W'(MIN_FRAME) : hdr_len;
    tot_c   = {1'b0, len_pad} + TOT_W'(HDR_BYTES);
  end

  rrb_link #(.PG_W(PG_W), .OFF_W(OFF_W), .TOT_W(TOT_W)) u_link (
    .start_pg(cfg_start_pg), .stop_pg(cfg_stop_pg), .cur_pg(cur_q),
    .total(tot_c), .next_pg(nxt_c));

  rrb_addr #(.PG_W(PG_W), .OFF_W(OFF_W)) u_addr (
    .addr(wa), .start_pg(cfg_start_pg), .stop_pg(cfg_stop_pg), .addr_nx(wa_nx));

  assign hdr_ready = (state == ST_IDLE);
  assign dat_ready = (state == ST_DATA) || (state == ST_DROP);
  assign busy      = (state != ST_IDLE);
  assign acc       = hdr_valid && hdr_ready;
  assign flag_set  = (state == ST_UPD);

  always_comb begin
    unique case (hcnt)
      HC_W'(0): hdr_byte = RX_GOOD;
      HC_W'(1): hdr_byte = 8'(nxt_q);
      HC_W'(2): hdr_byte = tot_q[7:0];
      default:  hdr_byte = 8'(tot_q >> 8);
    endcase
  end

  always_comb begin
    mem_we    = 1'b0;
    mem_addr  = wa;
    mem_wdata = 8'h00;
    unique case (state)
      ST_HDR: begin
        mem_we    = 1'b1;
        mem_addr  = {cur_q, OFF_W'(hcnt)};
        mem_wdata = hdr_byte;
      end
      ST_DATA: begin
        mem_we    = dat_valid;
        mem_wdata = dat_data;
      end
      ST_PAD: mem_we = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      hcnt    <= '0;
      rem     <= '0;
      pad_rem <= '0;
      wa      <= '0;
      nxt_q   <= '0;
      tot_q   <= '0;
      cur_q   <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (cur_ld) cur_q <= cur_ld_pg;
          if (acc) begin
            rem <= hdr_len;
            if (cmd_stop || full_c) begin
              state <= (hdr_len == '0) ? ST_IDLE : ST_DROP;
            end else begin
              state   <= ST_HDR;
              hcnt    <= '0;
              pad_rem <= (hdr_len < LEN_W'(MIN_FRAME)) ? LEN_W'(MIN_FRAME) - hdr_len : '0;
              wa      <= {cur_q, OFF_W'(HDR_BYTES)};
              nxt_q   <= nxt_c;
              tot_q   <= tot_c;
            end
          end
        end
        ST_HDR: begin
          hcnt <= hcnt + HC_W'(1);
          if (hcnt == HC_W'(HDR_BYTES - 1))
            state <= (rem != '0) ? ST_DATA : ST_PAD;
        end
        ST_DATA: if (dat_valid) begin
          wa  <= wa_nx;
          rem <= rem - LEN_W'(1);
          if (rem == LEN_W'(1)) state <= (pad_rem != '0) ? ST_PAD : ST_UPD;
        end
        ST_PAD: begin
          wa      <= wa_nx;
          pad_rem <= pad_rem - LEN_W'(1);
          if (pad_rem == LEN_W'(1)) state <= ST_UPD;
        end
        ST_UPD: begin
          cur_q <= nxt_q;
          state <= ST_IDLE;
        end
        ST_DROP: if (dat_valid) begin
          rem <= rem - LEN_W'(1);
          if (rem == LEN_W'(1)) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= (flag_q && !isr_clr[0]) || flag_set;
  end

  assign status_vec = {7'b0, flag_q};
  assign irq        = |(status_vec & irq_mask & 8'h7F);
  assign cur_pg     = cur_q;
  assign rx_flag    = flag_q;
endmodule

// File: rtl/rrb_ring_writer_chk.sv
module rrb_ring_writer_chk #(
  parameter int PG_W  = 8,
  parameter int OFF_W = 8
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [PG_W-1:0]       cfg_start_pg,
  input logic [PG_W-1:0]       cfg_stop_pg,
  input logic                  cmd_stop,
  input logic                  cur_ld,
  input logic                  hdr_valid,
  input logic                  hdr_ready,
  input logic                  dat_valid,
  input logic                  dat_ready,
  input logic                  mem_we,
  input logic [PG_W+OFF_W-1:0] mem_addr,
  input logic                  busy,
  input logic [PG_W-1:0]       cur_pg,
  input logic                  rx_flag,
  input logic                  irq
);
  localparam int AW = PG_W + OFF_W;

  // R1
  write_only_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> busy);

  // R1
  busy_from_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(hdr_valid && hdr_ready));

  // R2
  stopped_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_valid && hdr_ready && cmd_stop) |=> !mem_we);

  // R6
  write_in_ring_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_addr[AW-1:OFF_W] >= cfg_start_pg && mem_addr[AW-1:OFF_W] < cfg_stop_pg));

  // R8
  cur_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cur_pg) |-> ($past(busy) || $past(cur_ld)));

  // R9
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_flag |-> !irq);

  // R11
  write_on_handshake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && dat_ready) |-> dat_valid);
endmodule

bind rrb_ring_writer rrb_ring_writer_chk #(.PG_W(PG_W), .OFF_W(OFF_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_start_pg(cfg_start_pg), .cfg_stop_pg(cfg_stop_pg),
  .cmd_stop(cmd_stop), .cur_ld(cur_ld), .hdr_valid(hdr_valid), .hdr_ready(hdr_ready),
  .dat_valid(dat_valid), .dat_ready(dat_ready), .mem_we(mem_we), .mem_addr(mem_addr),
  .busy(busy), .cur_pg(cur_pg), .rx_flag(rx_flag), .irq(irq));

// File: tb/rrb_ring_writer_tb.sv
module rrb_ring_writer_tb;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [15:0] len;
    logic [7:0]  cur;
    logic [7:0]  bnd;
    logic [7:0]  start;
    logic [7:0]  stop;
    logic [7:0]  exp_next;
    logic        exp_drop;
  } vec_t;

  // R3 R7 vectors: ring 0x10..0x17 unless noted
  localparam vec_t TBL [8] = '{
    '{16'd100,  8'h10, 8'h10, 8'h10, 8'h18, 8'h11, 1'b0},
    '{16'd20,   8'h11, 8'h10, 8'h10, 8'h18, 8'h12, 1'b0},
    '{16'd600,  8'h16, 8'h15, 8'h10, 8'h18, 8'h11, 1'b0},
    '{16'd300,  8'h12, 8'h15, 8'h10, 8'h18, 8'h12, 1'b1},
    '{16'd1514, 8'h10, 8'h10, 8'h10, 8'h18, 8'h16, 1'b0},
    '{16'd80,   8'h12, 8'h10, 8'h18, 8'h10, 8'h12, 1'b1},
    '{16'd60,   8'h17, 8'h17, 8'h10, 8'h18, 8'h10, 1'b0},
    '{16'd200,  8'h10, 8'h16, 8'h10, 8'h18, 8'h11, 1'b0}
  };

  logic        clk = 0, rst_n = 0;
  logic [7:0]  cfg_start_pg = 8'h10, cfg_stop_pg = 8'h18, cfg_bnd_pg = 8'h10;
  logic        cmd_stop = 0;
  logic [7:0]  irq_mask = 8'h00, isr_clr = 8'h00;
  logic        cur_ld = 0;
  logic [7:0]  cur_ld_pg = 8'h00;
  logic        hdr_valid = 0, hdr_ready;
  logic [10:0] hdr_len = '0;
  logic        dat_valid = 0, dat_ready;
  logic [7:0]  dat_data = '0;
  logic        mem_we;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic        busy, rx_flag, irq;
  logic [7:0]  cur_pg;

  logic [7:0] mem [0:4095];
  int n_tests = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rrb_ring_writer u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_start_pg(cfg_start_pg), .cfg_stop_pg(cfg_stop_pg),
    .cfg_bnd_pg(cfg_bnd_pg), .cmd_stop(cmd_stop), .irq_mask(irq_mask), .isr_clr(isr_clr),
    .cur_ld(cur_ld), .cur_ld_pg(cur_ld_pg), .hdr_valid(hdr_valid), .hdr_ready(hdr_ready),
    .hdr_len(hdr_len), .dat_valid(dat_valid), .dat_ready(dat_ready), .dat_data(dat_data),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .busy(busy),
    .cur_pg(cur_pg), .rx_flag(rx_flag), .irq(irq));

  always @(posedge clk) if (mem_we) mem[mem_addr[11:0]] <= mem_wdata;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int k, input int v);
    return 8'(k * 3 + v);
  endfunction

  function automatic int byte_addr(input int cur, input int k, input int st, input int sp);
    int a = cur * 256 + 4 + k;
    if (a >= sp * 256) a -= (sp - st) * 256;
    return a;
  endfunction

  task automatic fill_mem();
    for (int i = 0; i < 4096; i++) mem[i] = 8'hAA;
  endtask

  task automatic clear_flag();
    @(negedge clk); isr_clr = 8'h01;
    @(negedge clk); isr_clr = 8'h00;
  endtask

  task automatic load_cur(input logic [7:0] pg);
    @(negedge clk); cur_ld = 1; cur_ld_pg = pg;
    @(negedge clk); cur_ld = 0;
  endtask

  task automatic send_frame(input int len, input int v, input bit gap);
    @(negedge clk);
    hdr_valid = 1; hdr_len = 11'(len);
    while (!hdr_ready) @(negedge clk);
    @(negedge clk);
    hdr_valid = 0;
    for (int k = 0; k < len; k++) begin
      if (gap && k == 5) begin dat_valid = 0; @(negedge clk); @(negedge clk); end
      dat_valid = 1; dat_data = pat(k, v);
      while (!dat_ready) @(negedge clk);
      @(negedge clk);
    end
    dat_valid = 0;
    while (busy) @(negedge clk);
  endtask

  task automatic check_stored(input int cur, input int len, input int nxt, input int st,
                              input int sp, input int v, input string tag);
    int lp = (len < 60) ? 60 : len;
    int tot = lp + 4;
    int a;
    chk(mem[12'(cur * 256)] == 8'h01, {tag, " R4 status"}, mem[12'(cur * 256)], 1);
    chk(mem[12'(cur * 256 + 1)] == 8'(nxt), {tag, " R4 R7 link"}, mem[12'(cur * 256 + 1)], nxt);
    chk(mem[12'(cur * 256 + 2)] == 8'(tot), {tag, " R4 len lo"}, mem[12'(cur * 256 + 2)], tot & 255);
    chk(mem[12'(cur * 256 + 3)] == 8'(tot >> 8), {tag, " R4 len hi"}, mem[12'(cur * 256 + 3)], tot >> 8);
    if (len > 0) begin
      a = byte_addr(cur, 0, st, sp);
      chk(mem[12'(a)] == pat(0, v), {tag, " R6 first byte"}, mem[12'(a)], pat(0, v));
      a = byte_addr(cur, len - 1, st, sp);
      chk(mem[12'(a)] == pat(len - 1, v), {tag, " R6 R11 last byte"}, mem[12'(a)], pat(len - 1, v));
    end
    a = byte_addr(cur, lp - 1, st, sp);
    if (lp > len)
      chk(mem[12'(a)] == 8'h00, {tag, " R5 pad"}, mem[12'(a)], 0);
    a = byte_addr(cur, lp, st, sp);
    chk(mem[12'(a)] == 8'hAA, {tag, " R6 no overrun"}, mem[12'(a)], 8'hAA);
    chk(cur_pg == 8'(nxt), {tag, " R8 cur"}, cur_pg, nxt);
    chk(rx_flag == 1'b1, {tag, " R8 flag"}, rx_flag, 1);
  endtask

  initial begin
    for (int c = 0; c < 100000; c++) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    fill_mem();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // reset state
    chk(busy == 0, "R1 reset busy", busy, 0);
    chk(hdr_ready == 1, "R1 reset ready", hdr_ready, 1);
    chk(cur_pg == 0, "R8 reset cur", cur_pg, 0);
    chk(rx_flag == 0 && irq == 0, "R9 reset irq", irq, 0);

    // table walk
    for (int i = 0; i < 8; i++) begin
      vec_t t = TBL[i];
      fill_mem();
      cfg_start_pg = t.start; cfg_stop_pg = t.stop; cfg_bnd_pg = t.bnd;
      load_cur(t.cur);
      clear_flag();
      chk(cur_pg == t.cur, "R10 idle load", cur_pg, t.cur);
      send_frame(int'(t.len), i, i[0]);
      if (t.exp_drop) begin
        chk(cur_pg == t.cur, "R2 R3 drop cur", cur_pg, t.cur);
        chk(rx_flag == 0, "R2 drop flag", rx_flag, 0);
        chk(mem[12'(int'(t.cur) * 256)] == 8'hAA, "R2 drop no write", mem[12'(int'(t.cur) * 256)], 8'hAA);
      end else begin
        check_stored(int'(t.cur), int'(t.len), int'(t.exp_next), int'(t.start), int'(t.stop), i,
                     $sformatf("vec%0d R3", i));
      end
    end

    // zero-length frame: 60 zeros
    fill_mem();
    cfg_start_pg = 8'h10; cfg_stop_pg = 8'h18; cfg_bnd_pg = 8'h10;
    load_cur(8'h10); clear_flag();
    send_frame(0, 0, 0);
    check_stored(16'h10, 0, 8'h11, 8'h10, 8'h18, 0, "len0 R5");
    chk(mem[12'h004] == 8'h00, "R5 len0 first pad", mem[12'h004], 0);

    // receiver stopped
    fill_mem(); clear_flag();
    cmd_stop = 1;
    send_frame(70, 3, 0);
    cmd_stop = 0;
    chk(cur_pg == 8'h11, "R2 stopped cur", cur_pg, 8'h11);
    chk(rx_flag == 0, "R2 stopped flag", rx_flag, 0);
    chk(mem[12'h104] == 8'hAA, "R2 stopped no write", mem[12'h104], 8'hAA);

    // host load ignored while busy
    load_cur(8'h10); clear_flag();
    @(negedge clk); hdr_valid = 1; hdr_len = 11'd100;
    @(negedge clk); hdr_valid = 0;
    cur_ld = 1; cur_ld_pg = 8'h15;
    @(negedge clk); cur_ld = 0;
    for (int k = 0; k < 100; k++) begin
      dat_valid = 1; dat_data = pat(k, 1);
      while (!dat_ready) @(negedge clk);
      @(negedge clk);
    end
    dat_valid = 0;
    while (busy) @(negedge clk);
    chk(cur_pg == 8'h11, "R10 busy load ignored", cur_pg, 8'h11);

    // interrupt mask and clear
    irq_mask = 8'h00; @(negedge clk);
    chk(irq == 0, "R9 masked", irq, 0);
    irq_mask = 8'hFE; @(negedge clk);
    chk(irq == 0, "R9 other bits", irq, 0);
    irq_mask = 8'h01; @(negedge clk);
    chk(irq == 1, "R9 enabled", irq, 1);
    clear_flag();
    chk(rx_flag == 0 && irq == 0, "R12 clear", rx_flag, 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule